// File: doc/BRIEF.md
# Programmable Input Qualification Filter

This block cleans up a single asynchronous input pin before the rest of the chip sees it. The pin first passes through a two-flop synchroniser. In qualified mode, a free-running prescaler then produces a sample strobe once every n system clocks. On each strobe the synchronised level is shifted into a short sample history. The filtered output moves to a new level only when the m most recent samples all show that level. Otherwise it keeps the level it had.

The sample period n is picked at run time through an 8-bit field, and m is either 3 or 6. Two other modes bypass the filter. One delivers the synchronised input with no filtering. The other connects the raw pin straight to the output with no clocked stage at all. The strobe is not aligned to input edges. A level held for n*m clocks therefore always qualifies, while a level held slightly less than that may or may not qualify, depending on where the strobe phase falls. All controls are plain static levels; there is no streaming data path and no handshake.

Top module: `iqf_top`

## Requirements
- R1: With `mode` = 2'b00 (synchronise only), `pin_out` equals `pin_in` delayed by exactly two rising clock edges, and a one-cycle pulse reaches the output.
- R2: With `mode` = 2'b10 or 2'b11 (bypass), `pin_out` follows `pin_in` combinationally, with no clock edge in between.
- R3: The sample period is n = 1 clock when `period_k` is 0 and n = 2*`period_k` clocks otherwise, so n ranges from 1 to 510. The strobe counter runs freely from reset and takes no notice of input edges.
- R4: `six_samples` = 0 selects m = 3 agreeing samples, and `six_samples` = 1 selects m = 6.
- R5: With `mode` = 2'b01 (qualified), an input level held for at least n*m clocks always reaches `pin_out`, and `pin_out` then returns once the input has been back at its previous level for n*m clocks.
- R6: In qualified mode, a pulse no longer than n*(m-1) clocks never changes `pin_out`.
- R7: In qualified mode, `pin_out` holds its value while the m most recent samples disagree, and it changes only on a sample strobe.
- R8: While `rst_n` is low, the synchroniser flops, the sample history and the qualified output are all forced to the parameter `RST_VAL`. Just after reset, the qualified output shows `RST_VAL` even if the pin is at the other level.
- R9: With n = 1 in qualified mode, a change on `pin_in` reaches `pin_out` on the (2+m)-th rising edge after the change, and not on an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw asynchronous pin level |
| mode | input | 2 | 00 synchronise only, 01 qualified, 10/11 bypass |
| period_k | input | PERIOD_W | Sample period code k: n = 1 if k = 0, else n = 2k |
| six_samples | input | 1 | 0: three samples must agree, 1: six samples |
| pin_out | output | 1 | Filtered pin level |

## Verification
The bench builds the block with its default parameters: an 8-bit period field, a six-deep history with three as the short count, two synchroniser stages and a reset level of 0. With these values the bench can reach the full period range, from a single clock up to 510 clocks, with both sample counts. At every tested period it applies pulses of exactly n*m clocks, which must qualify, and of n*(m-1) clocks, which must be rejected. The single-clock period lets the bench check the exact edge on which the output changes, and the same setting is used for the hold test with disagreeing samples.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  typedef enum logic [1:0] {
    IQF_SYNC   = 2'b00,
    IQF_QUAL   = 2'b01,
    IQF_BYP_A  = 2'b10,
    IQF_BYP_B  = 2'b11
  } iqf_mode_e;
endpackage

// File: rtl/iqf_sync.sv
module iqf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/iqf_prescale.sv
module iqf_prescale #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_k,
  output logic                strobe
);
  localparam int CNT_W = PERIOD_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // n = 1 for k = 0, otherwise n = 2k; limit is n - 1
  always_comb begin
    if (period_k == '0) limit = '0;
    else                limit = ({1'b0, period_k} << 1) - CNT_W'(1);
  end

  assign strobe = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (strobe) cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end

  // R3: counter stays inside the programmed period while k is steady
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(period_k) |-> (cnt <= limit));

  // R3: with n >= 2 two strobes never come back to back
  p_strobe_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && period_k != '0 && $stable(period_k))
      |=> (!strobe || !$stable(period_k)));
endmodule

// File: rtl/iqf_history.sv
module iqf_history #(
  parameter int   HIST_D  = 6,
  parameter int   M_LO    = 3,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic sample,
  input  logic six,
  output logic qout
);
  logic [HIST_D-1:0] hist;
  logic [HIST_D-1:0] hist_nxt;
  logic [HIST_D-1:0] mask;
  logic              all_hi;
  logic              all_lo;

  // window of samples taking part in the vote
  always_comb begin
    for (int i = 0; i < HIST_D; i++) mask[i] = (i < M_LO) || six;
  end

  assign hist_nxt = {hist[HIST_D-2:0], sample};
  assign all_hi   = ((hist_nxt & mask) == mask);
  assign all_lo   = ((hist_nxt & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= {HIST_D{RST_VAL}};
      qout <= RST_VAL;
    end else if (strobe) begin
      hist <= hist_nxt;
      if (all_hi)      qout <= 1'b1;
      else if (all_lo) qout <= 1'b0;
    end
  end

  // R7: without a strobe the qualified level never moves
  p_hold_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(qout));

  // R5: a new level is only taken when every voting sample shows it
  p_change_agrees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (qout != $past(qout)) |->
      ((hist & $past(mask)) == ($past(mask) & {HIST_D{qout}})));
endmodule

// File: rtl/iqf_top.sv
module iqf_top
  import iqf_pkg::*;
#(
  parameter int   PERIOD_W    = 8,
  parameter int   HIST_D      = 6,
  parameter int   M_LO        = 3,
  parameter int   SYNC_STAGES = 2,
  parameter logic RST_VAL     = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin_in,
  input  logic [1:0]          mode,
  input  logic [PERIOD_W-1:0] period_k,
  input  logic                six_samples,
  output logic                pin_out
);
  iqf_mode_e mode_e;
  logic      sync_q;
  logic      strobe;
  logic      qual_q;

  assign mode_e = iqf_mode_e'(mode);

  iqf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_VAL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q));

  iqf_prescale #(.PERIOD_W(PERIOD_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .period_k(period_k), .strobe(strobe));

  iqf_history #(.HIST_D(HIST_D), .M_LO(M_LO), .RST_VAL(RST_VAL)) u_hist (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sample(sync_q),
    .six(six_samples), .qout(qual_q));

  always_comb begin
    case (mode_e)
      IQF_SYNC: pin_out = sync_q;
      IQF_QUAL: pin_out = qual_q;
      default:  pin_out = pin_in;
    endcase
  end

  // cycles since reset, used only to keep the delay check inside that window
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1: synchronise-only output is the pin two edges earlier
  p_sync_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && mode == 2'b00) |-> (pin_out == $past(pin_in, 2)));
endmodule

// File: tb/iqf_top_tb_top.sv
module iqf_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [7:0] period_k = 8'd0;
  logic       six_samples = 1'b0;
  logic       pin_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  iqf_top dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode(mode),
    .period_k(period_k), .six_samples(six_samples), .pin_out(pin_out));

  // {mode[1:0], k[7:0], six, width[11:0], must_pass}
  localparam int NV = 14;
  localparam logic [23:0] VECS [0:NV-1] = '{
    {2'b01, 8'd0,   1'b0, 12'd3,    1'b1},
    {2'b01, 8'd0,   1'b0, 12'd2,    1'b0},
    {2'b01, 8'd0,   1'b1, 12'd6,    1'b1},
    {2'b01, 8'd0,   1'b1, 12'd5,    1'b0},
    {2'b01, 8'd1,   1'b0, 12'd6,    1'b1},
    {2'b01, 8'd1,   1'b0, 12'd4,    1'b0},
    {2'b01, 8'd2,   1'b1, 12'd24,   1'b1},
    {2'b01, 8'd2,   1'b1, 12'd20,   1'b0},
    {2'b01, 8'd255, 1'b0, 12'd1530, 1'b1},
    {2'b01, 8'd255, 1'b0, 12'd1020, 1'b0},
    {2'b01, 8'd255, 1'b1, 12'd3060, 1'b1},
    {2'b01, 8'd255, 1'b1, 12'd2550, 1'b0},
    {2'b00, 8'd5,   1'b1, 12'd1,    1'b1},
    {2'b10, 8'd0,   1'b0, 12'd1,    1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic run_vec(input logic [23:0] v);
    int  n, m, w;
    bit  seen;
    string tag;
    n = (v[21:14] == 8'd0) ? 1 : 2 * int'(v[21:14]);
    m = v[13] ? 6 : 3;
    w = int'(v[12:1]);
    if (v[23:22] == 2'b01) tag = v[0] ? "R3 R4 R5" : "R3 R4 R6";
    else if (v[23:22] == 2'b00) tag = "R1";
    else tag = "R2";
    @(negedge clk);
    mode = v[23:22]; period_k = v[21:14]; six_samples = v[13]; pin_in = 1'b0;
    repeat (n * m + 20) @(negedge clk);
    seen = 1'b0;
    pin_in = 1'b1;
    repeat (w) begin
      @(negedge clk);
      if (pin_out) seen = 1'b1;
    end
    pin_in = 1'b0;
    repeat (n * m + 20) begin
      @(negedge clk);
      if (pin_out) seen = 1'b1;
    end
    chk(seen == v[0], {tag, " pulse outcome"}, seen, v[0]);
    chk(pin_out == 1'b0, {tag, " returns to low"}, pin_out, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    // R8: reset with the pin at the opposite level
    pin_in = 1'b1; mode = 2'b01; period_k = 8'd0; six_samples = 1'b0;
    repeat (3) @(negedge clk);
    chk(pin_out == 1'b0, "R8 output in reset", pin_out, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(pin_out == 1'b0, "R8 output just after reset", pin_out, 1'b0);
    pin_in = 1'b0;
    repeat (10) @(negedge clk);
    chk(pin_out == 1'b0, "R8 settled low", pin_out, 1'b0);

    // R9: n = 1, m = 3 -> change on edge 5
    pin_in = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pin_out == 1'b0, "R9 m3 not before edge 5", pin_out, 1'b0);
    @(posedge clk); @(negedge clk);
    chk(pin_out == 1'b1, "R9 m3 on edge 5", pin_out, 1'b1);

    // R4 with R9: n = 1, m = 6 -> change on edge 8
    six_samples = 1'b1;
    repeat (10) @(negedge clk);
    pin_in = 1'b0;
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk(pin_out == 1'b1, "R4 m6 not before edge 8", pin_out, 1'b1);
    @(posedge clk); @(negedge clk);
    chk(pin_out == 1'b0, "R4 m6 on edge 8", pin_out, 1'b0);

    // R7: disagreeing samples, never three highs in a row
    six_samples = 1'b0;
    repeat (10) @(negedge clk);
    begin
      bit moved;
      moved = 1'b0;
      for (int i = 0; i < 18; i++) begin
        pin_in = (i % 3 != 2);
        @(negedge clk);
        if (pin_out) moved = 1'b1;
      end
      pin_in = 1'b0;
      repeat (6) begin
        @(negedge clk);
        if (pin_out) moved = 1'b1;
      end
      chk(moved == 1'b0, "R7 hold on mixed samples", moved, 1'b0);
    end

    // R1: synchronise-only delay of two edges
    mode = 2'b00;
    repeat (5) @(negedge clk);
    pin_in = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(pin_out == 1'b0, "R1 not after one edge", pin_out, 1'b0);
    @(posedge clk); @(negedge clk);
    chk(pin_out == 1'b1, "R1 after two edges", pin_out, 1'b1);
    pin_in = 1'b0;
    repeat (3) @(negedge clk);

    // R2: bypass follows the pin with no clock edge
    mode = 2'b10;
    #2 pin_in = 1'b1;
    #1 chk(pin_out == 1'b1, "R2 bypass 10 rise", pin_out, 1'b1);
    mode = 2'b11;
    #1 pin_in = 1'b0;
    #1 chk(pin_out == 1'b0, "R2 bypass 11 fall", pin_out, 1'b0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule